// File: doc/BRIEF.md
# Motor Bridge Protection and Standby Supervisor

This block decides, one clock at a time, whether the H-bridge output stages and the gate charge pump of a two-phase bipolar motor driver may run. It receives a run-request level from outside, which is asynchronous and passes through a synchroniser. It also receives digital flags from analog monitors: a thermal trip flag, a separate "cooled below hysteresis" flag, an overcurrent trip flag, and two supply-good flags, one for the logic rail and one for the motor rail. From these it produces a global bridge enable, a charge-pump enable, a thermal status output and an internal reset pulse.

Thermal and overcurrent trips are latched. Either latch releases only when the run request goes low and then high again. For the thermal latch the release also requires the cooled flag to be high at the moment of the rising edge. While the charge pump runs, a start-up counter delays the bridge enable so that the gate supply has time to charge. A supply-rail dip raises the internal reset. The reset clears both latches and restarts the start-up wait, so the bridge returns after the wait once the rails recover.

The supply and trip flags are taken to be synchronous to `clk`. The run request is the only input that is synchronised.

Top module: `bridge_supervisor`

## Requirements
- R1: With the synchronised run request low, `bridge_en` and `pump_en` are both 0. A falling run request removes them two clocks after the input changes.
- R2: After `run_req` rises with no fault latched and the rails good, `pump_en` rises two clocks after the input change. `bridge_en` rises exactly STARTUP_CYC clocks after `pump_en`.
- R3: A high `therm_trip` latches a thermal fault on the next clock edge. From then on `therm_status` is 1 and `bridge_en` and `pump_en` are 0, even after `therm_trip` drops.
- R4: The thermal latch clears only on a run-request rising edge that follows a falling edge seen while latched, and only if `therm_cool` is 1 at that rising edge. A low-high cycle with `therm_cool` at 0 leaves the latch set and the cycle must be repeated.
- R5: A high `overcur_trip` latches an overcurrent fault on the next edge, which turns off `bridge_en` and `pump_en` while `therm_status` stays 0. A low-high cycle of the run request clears it. After the clear, the start-up wait runs again before `bridge_en` returns.
- R6: When both faults are latched, the bridge stays off until both are released. A low-high cycle with `therm_cool` at 0 releases only the overcurrent fault.
- R7: If `logic_ok` or `motor_ok` is 0 on a clock edge, `sup_reset` is 1 after that edge, and `bridge_en` and `pump_en` are 0 for as long as it stays 1.
- R8: `sup_reset` clears both fault latches and reloads the start-up counter. With the run request held high, `bridge_en` returns STARTUP_CYC+1 clocks after the rails recover, with no run-request cycle needed.
- R9: After reset all four outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_req | input | 1 | Asynchronous run request, high = operate |
| therm_trip | input | 1 | Junction over-temperature flag |
| therm_cool | input | 1 | Junction below release threshold flag |
| overcur_trip | input | 1 | Output overcurrent flag |
| logic_ok | input | 1 | Logic rail above its return level |
| motor_ok | input | 1 | Motor rail above its return level |
| bridge_en | output | 1 | Global enable for both H-bridges |
| pump_en | output | 1 | Charge-pump run enable |
| therm_status | output | 1 | Thermal fault latched |
| sup_reset | output | 1 | Internal reset from a supply dip |

## Verification
The bench builds the block with STARTUP_CYC set to 8 and the default two synchroniser stages. With that setting the exact clock on which `bridge_en` rises can be checked, one cycle early and on the cycle itself, after a clean start, after a fault release and after a rail recovery. The short wait also leaves room for the repeated standby cycles needed by the hot-toggle and dual-fault scenarios. The default wait of 20000 clocks gets the same logic but only a wider counter.

// File: rtl/sup_pkg.sv
// Package: shared indices and types for the bridge supervisor.
// Assumes two latched fault classes; index order is only used for naming.
package sup_pkg;
    localparam int FLT_THERM   = 0;
    localparam int FLT_OVERCUR = 1;
    localparam int NUM_FLT     = 2;

    // Edge pulses from the synchronised run request
    typedef struct packed {
        logic rise;
        logic fall;
    } run_edge_t;
endpackage

// File: rtl/run_sync.sv
// Module: run_sync
// Brings the asynchronous run request into the clock domain through a
// chain of STAGES flops and produces one-cycle rise and fall pulses.
// Assumes STAGES >= 2.
module run_sync
    import sup_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      async_in,
    output logic      level,
    output run_edge_t edges
);
    logic [STAGES-1:0] chain;
    logic              level_d;

    // Synchroniser chain, shifting toward the MSB
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], async_in};
    end

    // Delayed copy of the synchronised level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) level_d <= 1'b0;
        else        level_d <= chain[STAGES-1];
    end

    assign level      = chain[STAGES-1];
    assign edges.rise = level & ~level_d;
    assign edges.fall = ~level & level_d;
endmodule

// File: rtl/fault_latch.sv
// Module: fault_latch
// Holds one protection fault. A set input latches it. A falling run edge
// seen while latched arms the release, and a following rising edge clears
// it. When NEEDS_COOL is 1 the clear also needs cool_ok at the rising edge.
// A rising edge without permission disarms. A set cancels any arming.
// clr_all (from supply reset) empties the latch at once.
module fault_latch
    import sup_pkg::*;
#(
    parameter bit NEEDS_COOL = 1'b0
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clr_all,
    input  logic      set,
    input  logic      cool_ok,
    input  run_edge_t edges,
    output logic      latched
);
    logic armed;
    logic may_release;

    // Release permission: the cool flag only matters in the thermal variant
    assign may_release = cool_ok | ~NEEDS_COOL;

    // Latch and arm state update
    always_ff @(posedge clk) begin
        if (!rst_n || clr_all) begin
            latched <= 1'b0;
            armed   <= 1'b0;
        end else if (set) begin
            latched <= 1'b1;
            armed   <= 1'b0;
        end else if (latched) begin
            if (edges.fall) begin
                armed <= 1'b1;
            end else if (edges.rise) begin
                if (armed && may_release) latched <= 1'b0;
                armed <= 1'b0;
            end
        end else begin
            armed <= 1'b0;
        end
    end
endmodule

// File: rtl/start_timer.sv
// Module: start_timer
// Counts the charge-pump start-up wait. While run is low the counter holds
// WAIT_CYC; while run is high it counts down to zero and stops there.
// done is high only at zero. Assumes WAIT_CYC >= 1.
module start_timer #(
    parameter int WAIT_CYC = 20000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CNT_W = $clog2(WAIT_CYC + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(WAIT_CYC);

    logic [CNT_W-1:0] cnt;

    // Reload while idle, count down while the pump runs
    always_ff @(posedge clk) begin
        if (!rst_n || !run)  cnt <= LOAD;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/bridge_supervisor.sv
// Module: bridge_supervisor
// Top of the protection and standby supervisor. It synchronises the run
// request, holds the thermal and overcurrent latches, registers the supply
// dip reset and runs the start-up wait. Assumes the trip and supply flags
// are already synchronous to clk.
module bridge_supervisor
    import sup_pkg::*;
#(
    parameter int STARTUP_CYC = 20000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_req,
    input  logic therm_trip,
    input  logic therm_cool,
    input  logic overcur_trip,
    input  logic logic_ok,
    input  logic motor_ok,
    output logic bridge_en,
    output logic pump_en,
    output logic therm_status,
    output logic sup_reset
);
    logic               run_lvl;
    run_edge_t          run_edges;
    logic [NUM_FLT-1:0] flt_set;
    logic [NUM_FLT-1:0] flt_lat;
    logic               dip_q;
    logic               wait_done;

    // Run request synchroniser and edge detector
    run_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (run_req),
        .level    (run_lvl),
        .edges    (run_edges)
    );

    // Supply dip registered into the internal reset
    always_ff @(posedge clk) begin
        if (!rst_n) dip_q <= 1'b0;
        else        dip_q <= ~(logic_ok & motor_ok);
    end

    assign flt_set[FLT_THERM]   = therm_trip;
    assign flt_set[FLT_OVERCUR] = overcur_trip;

    // One latch per fault class; only the thermal one waits for cooling
    for (genvar g = 0; g < NUM_FLT; g++) begin : g_flt
        fault_latch #(.NEEDS_COOL(g == FLT_THERM)) u_lat (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr_all (dip_q),
            .set     (flt_set[g]),
            .cool_ok (therm_cool),
            .edges   (run_edges),
            .latched (flt_lat[g])
        );
    end

    assign pump_en = run_lvl & ~(|flt_lat) & ~dip_q;

    // Start-up wait while the pump charges
    start_timer #(.WAIT_CYC(STARTUP_CYC)) u_wait (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (pump_en),
        .done  (wait_done)
    );

    assign bridge_en    = pump_en & wait_done;
    assign therm_status = flt_lat[FLT_THERM];
    assign sup_reset    = dip_q;
endmodule

// File: rtl/bridge_supervisor_chk.sv
// Module: bridge_supervisor_chk
// Concurrent checks on the supervisor, bound into every instance.
module bridge_supervisor_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       run_lvl,
    input logic       run_rise,
    input logic       therm_trip,
    input logic       overcur_trip,
    input logic       logic_ok,
    input logic       motor_ok,
    input logic [1:0] flt_lat,
    input logic       bridge_en,
    input logic       pump_en,
    input logic       therm_status,
    input logic       sup_reset
);
    AST_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !run_lvl |-> (!pump_en && !bridge_en)); // R1
    AST_BRIDGE_AFTER_PUMP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bridge_en) |-> $past(pump_en)); // R2
    AST_THERM_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (therm_trip && !sup_reset) |=> therm_status); // R3
    AST_THERM_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(therm_status) |-> ($past(run_rise) || $past(sup_reset))); // R4
    AST_OC_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (overcur_trip && !sup_reset) |=> (!pump_en && !bridge_en)); // R5
    AST_FAULT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (|flt_lat) |-> (!pump_en && !bridge_en)); // R6
    AST_DIP_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !(logic_ok && motor_ok) |=> (sup_reset && !pump_en)); // R7
    AST_DIP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (sup_reset && !therm_trip && !overcur_trip) |=> (flt_lat == 2'b00)); // R8
endmodule

bind bridge_supervisor bridge_supervisor_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .run_lvl      (run_lvl),
    .run_rise     (run_edges.rise),
    .therm_trip   (therm_trip),
    .overcur_trip (overcur_trip),
    .logic_ok     (logic_ok),
    .motor_ok     (motor_ok),
    .flt_lat      (flt_lat),
    .bridge_en    (bridge_en),
    .pump_en      (pump_en),
    .therm_status (therm_status),
    .sup_reset    (sup_reset)
);

// File: tb/tb_bridge_supervisor.sv
`timescale 1ns/1ps
module tb_bridge_supervisor;
    localparam int S = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_req = 1'b0, therm_trip = 1'b0, therm_cool = 1'b1, overcur_trip = 1'b0;
    logic logic_ok = 1'b1, motor_ok = 1'b1;
    logic bridge_en, pump_en, therm_status, sup_reset;
    int   n_run = 0, n_bad = 0;
    bit   finished = 1'b0;

    always #2.5 clk = ~clk;

    bridge_supervisor #(.STARTUP_CYC(S), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .run_req(run_req), .therm_trip(therm_trip),
        .therm_cool(therm_cool), .overcur_trip(overcur_trip), .logic_ok(logic_ok),
        .motor_ok(motor_ok), .bridge_en(bridge_en), .pump_en(pump_en),
        .therm_status(therm_status), .sup_reset(sup_reset)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // Low-high cycle of run_req; leaves input high just after a negedge
    task automatic cycle_run();
        run_req = 1'b0;
        tick(4);
        run_req = 1'b1;
    endtask

    task automatic t_reset();
        tick(3);
        check("R9", "bridge_en", bridge_en, 1'b0);
        check("R9", "pump_en", pump_en, 1'b0);
        check("R9", "therm_status", therm_status, 1'b0);
        check("R9", "sup_reset", sup_reset, 1'b0);
        rst_n = 1'b1;
        tick(3);
        check("R1", "idle bridge_en", bridge_en, 1'b0);
        check("R1", "idle pump_en", pump_en, 1'b0);
    endtask

    task automatic t_clean_start();
        run_req = 1'b1;
        tick(1);
        check("R2", "pump before sync", pump_en, 1'b0);
        tick(1);
        check("R2", "pump after sync", pump_en, 1'b1);
        tick(S - 1);
        check("R2", "bridge one early", bridge_en, 1'b0);
        tick(1);
        check("R2", "bridge on time", bridge_en, 1'b1);
        run_req = 1'b0;
        tick(1);
        check("R1", "bridge one after fall", bridge_en, 1'b1);
        tick(1);
        check("R1", "bridge off", bridge_en, 1'b0);
        check("R1", "pump off", pump_en, 1'b0);
        run_req = 1'b1;
        tick(S + 2);
        check("R2", "restart bridge", bridge_en, 1'b1);
    endtask

    task automatic t_thermal();
        therm_trip = 1'b1; therm_cool = 1'b0;
        tick(1);
        check("R3", "therm_status", therm_status, 1'b1);
        check("R3", "bridge off", bridge_en, 1'b0);
        check("R3", "pump off", pump_en, 1'b0);
        therm_trip = 1'b0;
        tick(4);
        check("R3", "stays latched", therm_status, 1'b1);
        cycle_run();
        tick(S + 4);
        check("R4", "hot toggle keeps latch", therm_status, 1'b1);
        check("R4", "hot toggle bridge off", bridge_en, 1'b0);
        therm_cool = 1'b1;
        tick(4);
        check("R4", "cool without toggle", therm_status, 1'b1);
        cycle_run();
        tick(S + 2);
        check("R4", "released, bridge one early", bridge_en, 1'b0);
        check("R4", "released status", therm_status, 1'b0);
        tick(1);
        check("R4", "released bridge", bridge_en, 1'b1);
    endtask

    task automatic t_overcurrent();
        overcur_trip = 1'b1;
        tick(1);
        overcur_trip = 1'b0;
        check("R5", "bridge off", bridge_en, 1'b0);
        check("R5", "pump off", pump_en, 1'b0);
        check("R5", "no thermal status", therm_status, 1'b0);
        tick(S + 4);
        check("R5", "held off", pump_en, 1'b0);
        cycle_run();
        tick(S + 2);
        check("R5", "wait restarted", bridge_en, 1'b0);
        tick(1);
        check("R5", "released bridge", bridge_en, 1'b1);
    endtask

    task automatic t_dual();
        therm_trip = 1'b1; overcur_trip = 1'b1; therm_cool = 1'b0;
        tick(1);
        therm_trip = 1'b0; overcur_trip = 1'b0;
        check("R6", "both latched bridge", bridge_en, 1'b0);
        cycle_run();
        tick(S + 4);
        check("R6", "oc gone, thermal holds", therm_status, 1'b1);
        check("R6", "still off", pump_en, 1'b0);
        therm_cool = 1'b1;
        cycle_run();
        tick(S + 3);
        check("R6", "both released", bridge_en, 1'b1);
    endtask

    task automatic t_dip();
        overcur_trip = 1'b1;
        tick(1);
        overcur_trip = 1'b0;
        motor_ok = 1'b0;
        tick(1);
        check("R7", "motor dip reset", sup_reset, 1'b1);
        check("R7", "motor dip pump", pump_en, 1'b0);
        motor_ok = 1'b1;
        tick(1);
        check("R8", "reset released", sup_reset, 1'b0);
        tick(S - 1);
        check("R8", "bridge one early", bridge_en, 1'b0);
        tick(1);
        check("R8", "bridge back without toggle", bridge_en, 1'b1);
        logic_ok = 1'b0;
        tick(1);
        check("R7", "logic dip reset", sup_reset, 1'b1);
        check("R7", "logic dip bridge", bridge_en, 1'b0);
        logic_ok = 1'b1;
        tick(S + 1);
        check("R8", "logic recover bridge", bridge_en, 1'b1);
    endtask

    task automatic report();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    endtask

    initial begin
        tick(1);
        t_reset();
        t_clean_start();
        t_thermal();
        t_overcurrent();
        t_dual();
        t_dip();
        finished = 1'b1;
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            report();
        end
    end
endmodule